// File: doc/BRIEF.md
# Two-speed start-up clock controller

This block picks the clock source for the core after a reset or after a wake from sleep. When the primary oscillator is crystal based, it needs a long settling interval. If the fast start feature is on, the block runs the core from an internal oscillator that is always ready. Start-up counting goes on in parallel, and once the primary clock is stable the block moves the core to it without any action from firmware.

The controller counts rising edges of the primary oscillator. These edges are synchronised into the controller clock domain. In the PLL crystal mode, a lock interval of a given number of controller cycles follows the count. A short synchronisation count of primary edges then models the clock hand-over. Firmware may put the device back to sleep at any point before the switch, and every wake restarts the full count. For non-crystal modes, or when the feature is off, the count is skipped and the primary source is selected directly. The multiplexer itself is out of scope and is represented by a registered select.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: After rst_ni or while por_i is high, run_mode_o is 0 (reset), clk_sel_o is 0 and pri_active_o is 0. The block stays in this mode while pwrt_done_i is low.
- R2: The fast start is active when fast_start_en_i is 1 and osc_mode_i is below 4. The codes are 0 low-power crystal, 1 standard crystal, 2 high-speed crystal and 3 high-speed crystal with PLL. When the fast start is active, pwrt_done_i in reset mode moves the block to run_mode_o 1 (internal run) on the next cycle, with clk_sel_o 0 (internal).
- R3: When the fast start is inactive, pwrt_done_i in reset mode, or wake_i in sleep mode, moves the block on the next cycle to run_mode_o 2 (primary run), with clk_sel_o 1 and pri_active_o 1.
- R4: In a non-PLL crystal mode the block switches to primary run on the rising edge of pri_tick_i numbered OST_TICKS + SYNC_TICKS (default 1024 + 3). It switches within five cycles of that edge and not after any earlier edge.
- R5: In mode 3, the block waits at least pll_delay_i controller cycles after edge OST_TICKS. Primary edges seen during this wait are not counted. SYNC_TICKS further edges are then required before the switch.
- R6: sleep_req_i in internal run or primary run moves the block on the next cycle to run_mode_o 3 (sleep), with clk_sel_o 0 and pri_active_o 0. This happens even if the count is unfinished. Primary edges seen during sleep have no effect.
- R7: wake_i in sleep mode, with the fast start active, moves the block to internal run on the next cycle. The start-up count restarts from zero.
- R8: pri_active_o is 1 exactly when clk_sel_o selects the primary source.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fast_start_en_i | input | 1 | Configuration enable for fast start |
| osc_mode_i | input | 3 | Primary oscillator mode code |
| por_i | input | 1 | Power-on reset in progress |
| pwrt_done_i | input | 1 | Power-up timer finished |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_i | input | 1 | Wake event |
| pri_tick_i | input | 1 | Primary oscillator clock, asynchronous |
| pll_delay_i | input | PLL_W | PLL lock wait in controller cycles |
| clk_sel_o | output | 1 | Source select: 0 internal, 1 primary |
| pri_active_o | output | 1 | Primary clock drives the core |
| run_mode_o | output | 2 | 0 reset, 1 internal run, 2 primary run, 3 sleep |

## Verification
On every cycle the assertions check the mode transitions that a single input causes: holding in reset, entering sleep, the two kinds of wake, and the leave from reset. They also check that the status flag always agrees with the select. The exact number of primary edges before the switch can only be shown by the bench scenarios. The same holds for the PLL wait that ignores edges, the restart of the count after a sleep abort, and the bypass for non-crystal modes, which the bench drives with counted tick sequences.

// File: rtl/twospeed_clk_pkg.sv
package twospeed_clk_pkg;
  typedef enum logic [1:0] {
    RM_RESET = 2'd0,
    RM_INT   = 2'd1,
    RM_PRI   = 2'd2,
    RM_SLEEP = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    PH_OST  = 2'd0,
    PH_PLL  = 2'd1,
    PH_SYNC = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam logic [2:0] MODE_XTAL_PLL = 3'd3;
  localparam logic [2:0] MODE_XTAL_TOP = 3'd4;

  function automatic logic is_crystal(input logic [2:0] mode);
    return mode < MODE_XTAL_TOP;
  endfunction
endpackage

// File: rtl/twospeed_tick_sync.sv
module twospeed_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  localparam int LAST = (STAGES < 2) ? 2 : STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], tick_i};
  end

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/twospeed_startup_cnt.sv
module twospeed_startup_cnt
  import twospeed_clk_pkg::*;
#(
  parameter int OST_TICKS  = 1024,
  parameter int SYNC_TICKS = 3,
  parameter int PLL_W      = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pll_mode_i,
  input  logic [PLL_W-1:0] pll_delay_i,
  input  logic             rise_i,
  output logic             done_o
);
  localparam int MAXT = (OST_TICKS > SYNC_TICKS) ? OST_TICKS : SYNC_TICKS;
  localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_TICKS - 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_TICKS - 1);

  phase_e           phase_q;
  logic [CW-1:0]    cnt_q;
  logic [PLL_W-1:0] pll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OST;
      cnt_q   <= '0;
      pll_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_OST;
      cnt_q   <= '0;
      pll_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_OST: if (rise_i) begin
          if (cnt_q == OST_LAST) begin
            cnt_q   <= '0;
            phase_q <= pll_mode_i ? PH_PLL : PH_SYNC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        // lock wait in controller cycles, primary edges ignored
        PH_PLL: begin
          if (pll_q >= pll_delay_i) phase_q <= PH_SYNC;
          else                      pll_q   <= pll_q + 1'b1;
        end
        PH_SYNC: if (rise_i) begin
          if (cnt_q == SYNC_LAST) phase_q <= PH_DONE;
          else                    cnt_q   <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign done_o = (phase_q == PH_DONE);
endmodule

// File: rtl/twospeed_src_fsm.sv
module twospeed_src_fsm
  import twospeed_clk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fast_i,
  input  logic      por_i,
  input  logic      pwrt_done_i,
  input  logic      sleep_req_i,
  input  logic      wake_i,
  input  logic      cnt_done_i,
  output run_mode_e mode_o,
  output logic      sel_o,
  output logic      flag_o,
  output logic      cnt_run_o
);
  run_mode_e state_q, state_d;
  logic      sel_q, flag_q;

  always_comb begin
    state_d = state_q;
    if (por_i) begin
      state_d = RM_RESET;
    end else begin
      unique case (state_q)
        RM_RESET: if (pwrt_done_i) state_d = fast_i ? RM_INT : RM_PRI;
        RM_INT: begin
          if (sleep_req_i)     state_d = RM_SLEEP;
          else if (cnt_done_i) state_d = RM_PRI;
        end
        RM_PRI:   if (sleep_req_i) state_d = RM_SLEEP;
        RM_SLEEP: if (wake_i)      state_d = fast_i ? RM_INT : RM_PRI;
        default:  state_d = RM_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RM_RESET;
      sel_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= (state_d == RM_PRI);
      flag_q  <= (state_d == RM_PRI);
    end
  end

  assign mode_o    = state_q;
  assign sel_o     = sel_q;
  assign flag_o    = flag_q;
  assign cnt_run_o = (state_q == RM_INT);
endmodule

// File: rtl/twospeed_clk_ctrl.sv
module twospeed_clk_ctrl
  import twospeed_clk_pkg::*;
#(
  parameter int OST_TICKS   = 1024,
  parameter int SYNC_TICKS  = 3,
  parameter int PLL_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_start_en_i,
  input  logic [2:0]       osc_mode_i,
  input  logic             por_i,
  input  logic             pwrt_done_i,
  input  logic             sleep_req_i,
  input  logic             wake_i,
  input  logic             pri_tick_i,
  input  logic [PLL_W-1:0] pll_delay_i,
  output logic             clk_sel_o,
  output logic             pri_active_o,
  output logic [1:0]       run_mode_o
);
  logic      rise, cnt_run, cnt_done, fast, pll_mode;
  run_mode_e mode;

  assign fast     = fast_start_en_i & is_crystal(osc_mode_i);
  assign pll_mode = (osc_mode_i == MODE_XTAL_PLL);

  twospeed_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (pri_tick_i),
    .rise_o (rise)
  );

  twospeed_startup_cnt #(
    .OST_TICKS  (OST_TICKS),
    .SYNC_TICKS (SYNC_TICKS),
    .PLL_W      (PLL_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (cnt_run),
    .pll_mode_i  (pll_mode),
    .pll_delay_i (pll_delay_i),
    .rise_i      (rise),
    .done_o      (cnt_done)
  );

  twospeed_src_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_i      (fast),
    .por_i       (por_i),
    .pwrt_done_i (pwrt_done_i),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .cnt_done_i  (cnt_done),
    .mode_o      (mode),
    .sel_o       (clk_sel_o),
    .flag_o      (pri_active_o),
    .cnt_run_o   (cnt_run)
  );

  assign run_mode_o = mode;
endmodule

// File: rtl/twospeed_clk_chk.sv
module twospeed_clk_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fast_start_en_i,
  input logic [2:0] osc_mode_i,
  input logic       por_i,
  input logic       pwrt_done_i,
  input logic       sleep_req_i,
  input logic       wake_i,
  input logic       clk_sel_o,
  input logic       pri_active_o,
  input logic [1:0] run_mode_o
);
  logic fast_ok;
  assign fast_ok = fast_start_en_i && (osc_mode_i < 3'd4);

  // R1
  reset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode_o == 2'd0 && !pwrt_done_i) |=> (run_mode_o == 2'd0 && !clk_sel_o));

  // R1
  por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (run_mode_o == 2'd0 && !pri_active_o));

  // R2
  fast_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && run_mode_o == 2'd0 && pwrt_done_i && fast_ok) |=> (run_mode_o == 2'd1 && !clk_sel_o));

  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !fast_ok && ((run_mode_o == 2'd0 && pwrt_done_i) || (run_mode_o == 2'd3 && wake_i)))
    |=> (run_mode_o == 2'd2 && clk_sel_o && pri_active_o));

  // R6
  sleep_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && sleep_req_i && (run_mode_o == 2'd1 || run_mode_o == 2'd2))
    |=> (run_mode_o == 2'd3 && !clk_sel_o && !pri_active_o));

  // R7
  wake_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && run_mode_o == 2'd3 && wake_i && fast_ok) |=> (run_mode_o == 2'd1 && !clk_sel_o));

  // R8
  flag_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_active_o == clk_sel_o);
endmodule

bind twospeed_clk_ctrl twospeed_clk_chk u_chk (.*);

// File: tb/twospeed_clk_ctrl_test.sv
module twospeed_clk_ctrl_test;
  localparam int OST = 1024;
  localparam int SYN = 3;
  localparam int PW  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [2:0]    mode = 3'd2;
  logic          por = 1'b0, pwrt = 1'b0, slp = 1'b0, wake = 1'b0, tick = 1'b0;
  logic [PW-1:0] pll_dly = '0;
  logic          sel, flag;
  logic [1:0]    rmode;
  int            total = 0, bad = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  twospeed_clk_ctrl #(.OST_TICKS(OST), .SYNC_TICKS(SYN), .PLL_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fast_start_en_i(en), .osc_mode_i(mode),
    .por_i(por), .pwrt_done_i(pwrt), .sleep_req_i(slp), .wake_i(wake),
    .pri_tick_i(tick), .pll_delay_i(pll_dly),
    .clk_sel_o(sel), .pri_active_o(flag), .run_mode_o(rmode));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(4);
      tick = 1'b0; cyc(4);
    end
  endtask

  task automatic state_is(input string req, input int m, input int s);
    chk({req, " mode"}, rmode, m);
    chk({req, " sel"}, sel, s);
    chk({req, " flag"}, flag, s);
  endtask

  task automatic do_por(input logic e, input logic [2:0] m);
    en = e; mode = m; pwrt = 1'b0;
    por = 1'b1; cyc(2);
    por = 1'b0; cyc(3);
    state_is("R1 por hold", 0, 0);
    pwrt = 1'b1; cyc(1);
  endtask

  task automatic t_reset;
    cyc(3);
    state_is("R1 reset", 0, 0);
    rst_n = 1'b1; cyc(5);
    state_is("R1 pwrt low hold", 0, 0);
  endtask

  task automatic t_count;
    do_por(1'b1, 3'd2);
    state_is("R2 internal run", 1, 0);
    ticks(OST + SYN - 1);
    cyc(4);
    state_is("R4 one edge short", 1, 0);
    ticks(1);
    state_is("R4 switched", 2, 1);
    slp = 1'b1; cyc(1); slp = 1'b0;
    state_is("R6 sleep from primary", 3, 0);
    ticks(5);
    state_is("R6 edges in sleep", 3, 0);
  endtask

  task automatic t_pll;
    pll_dly = PW'(100);
    do_por(1'b1, 3'd3);
    state_is("R2 pll internal", 1, 0);
    ticks(OST);
    ticks(SYN);
    state_is("R5 edges in lock wait ignored", 1, 0);
    cyc(100);
    ticks(SYN - 1);
    state_is("R5 sync short", 1, 0);
    ticks(1);
    state_is("R5 switched", 2, 1);
  endtask

  task automatic t_abort;
    do_por(1'b1, 3'd0);
    ticks(500);
    slp = 1'b1; cyc(1); slp = 1'b0;
    state_is("R6 sleep abort", 3, 0);
    ticks(600);
    state_is("R6 sleep ignores edges", 3, 0);
    wake = 1'b1; cyc(1); wake = 1'b0;
    state_is("R7 wake internal", 1, 0);
    ticks(OST + SYN - 1);
    state_is("R7 count restarted", 1, 0);
    ticks(1);
    state_is("R7 switched after full count", 2, 1);
  endtask

  task automatic t_bypass;
    do_por(1'b1, 3'd5);
    state_is("R3 non-crystal direct", 2, 1);
    do_por(1'b0, 3'd1);
    state_is("R3 disabled direct", 2, 1);
    slp = 1'b1; cyc(1); slp = 1'b0;
    state_is("R6 sleep", 3, 0);
    en = 1'b0; mode = 3'd6;
    wake = 1'b1; cyc(1); wake = 1'b0;
    state_is("R3 wake bypass", 2, 1);
    chk("R8 flag matches sel", flag, sel);
  endtask

  initial begin
    t_reset();
    t_count();
    t_pll();
    t_abort();
    t_bypass();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule